// File: doc/BRIEF.md
# Receive Ring Frame Walker

This block steps through received frames held in a circular region of a packet RAM. It reads the RAM 16 bits at a time. The receiver ahead of it leaves a four-word header in front of every frame: a readiness word, a status word, a link to the next frame, and a byte count. On a poll request the walker fetches these words from its current read pointer and decides whether a frame is there and whether the frame is good. For a good frame it reports the payload's start address, its byte length and its length in words. It then moves the read pointer to the link, and it produces a new stop boundary that the receiver must not write past.

An initialise request places the read pointer at the bottom page of the region and sets the stop boundary near the top page. It also writes zero to the word under the pointer, so the first poll cannot mistake old RAM contents for a frame. Copying the payload out of the RAM is left to the logic that uses the reported address and length.

The controller's states are:
- `ST_IDLE`: waiting.
- `ST_CLEAR`: zeroing the first header word after an initialise.
- `ST_REQ_EVT`: issuing the read of the readiness word.
- `ST_GET_EVT`: the readiness word arrives and the status read is issued.
- `ST_GET_STS`: the status word arrives and the link read is issued.
- `ST_GET_LNK`: the link arrives and the count read is issued.
- `ST_GET_CNT`: the count arrives.
- `ST_CHECK`: the header is judged and the results are stored.
- `ST_GOOD`: the frame-ready pulse.
- `ST_BAD`: the error pulse.

The transitions are:
- A poll in `ST_IDLE` leads to `ST_REQ_EVT`.
- `ST_REQ_EVT` always leads to `ST_GET_EVT`.
- From `ST_GET_EVT` the walker goes to `ST_GET_STS` when a frame is present, and back to `ST_IDLE` when it is not.
- `ST_GET_STS` leads to `ST_GET_LNK`, then `ST_GET_CNT`, then `ST_CHECK`.
- `ST_CHECK` leads to `ST_GOOD` or to `ST_BAD`.
- `ST_GOOD`, `ST_BAD` and `ST_CLEAR` all return to `ST_IDLE`.
- An initialise request in any state leads to `ST_CLEAR`.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset the walker is idle. `busy_o`, `frame_ready_o`, `rx_error_o` and `stop_wr_o` are low, and `rd_ptr_o` is 0.
- R2: An initialise request sets `rd_ptr_o` to lower_page<<8 and `stop_o` to {upper_page, 0xFE}. It pulses `stop_wr_o` for one cycle and writes 0x0000 to the RAM word under the new pointer.
- R3: A frame is present only when the readiness word equals exactly 0x0008. Any other value ends the poll with no pulse on any output and leaves `rd_ptr_o` and `stop_o` unchanged.
- R4: The header words are read at word addresses ptr[15:1]+0, +1, +2 and +3, in that order: readiness, status, link, count. Read data returns one cycle after `mem_rd_o`.
- R5: A frame is good only when (status AND 0x2D81) equals 0x2000. Otherwise `rx_error_o` pulses, `stop_wr_o` stays low, and `rd_ptr_o` and `stop_o` are unchanged.
- R6: For a good frame, `pay_len_o` is count[13:0], `pay_addr_o` is ptr+8, and `pay_words_o` is (length+3)>>1.
- R7: For a good frame, `rd_ptr_o` becomes the link word, and `stop_o` becomes ptr+8+length−1, computed modulo 2^16. `stop_wr_o` pulses in the same cycle as `frame_ready_o`.
- R8: When ptr+8+length is 0 modulo 2^16, `stop_o` becomes {upper_page, 0xFF}−1.
- R9: `frame_ready_o` and `rx_error_o` are single-cycle pulses that never occur together. A poll raised while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialise request |
| poll_i | input | 1 | Poll request, taken when idle |
| lower_page_i | input | 8 | Lowest page of the receive region |
| upper_page_i | input | 8 | Highest page of the receive region |
| mem_rd_o | output | 1 | RAM read strobe |
| mem_wr_o | output | 1 | RAM write strobe |
| mem_addr_o | output | 15 | RAM word address |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, one cycle after the read |
| busy_o | output | 1 | High while not idle |
| frame_ready_o | output | 1 | Good frame pulse |
| rx_error_o | output | 1 | Bad frame pulse |
| pay_addr_o | output | 16 | Payload byte address |
| pay_len_o | output | 14 | Payload byte length |
| pay_words_o | output | 14 | Payload word count |
| rd_ptr_o | output | 16 | Current frame start pointer |
| stop_o | output | 16 | Stop boundary for the receiver |
| stop_wr_o | output | 1 | Stop boundary write strobe |

## Verification
The bench tests readiness words that are close to 0x0008 but not equal to it. A design that tests only some bits of that word would invent frames from stale data.

It feeds status words that have bits set outside the mask, and words that miss the required bit or carry an error bit. A design with a wrong mask would either pass corrupt frames or reject good ones.

It builds a frame whose end lands exactly on address zero. A design that skips the substitution would produce a stop of 0xFFFF. It also uses a byte count with its two top bits set, which would give an oversized length if those bits were not dropped.

Finally, it sends a second poll during a walk while the frame links back to itself. A design that accepted that poll would report the frame twice.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned HDR_BYTES = 8;
    localparam logic [WORD_W-1:0] EVT_FRAME = 16'h0008;
    localparam logic [WORD_W-1:0] STS_GOOD  = 16'h2000;
    localparam logic [WORD_W-1:0] STS_MASK  = 16'h2D81;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_REQ_EVT,
        ST_GET_EVT,
        ST_GET_STS,
        ST_GET_LNK,
        ST_GET_CNT,
        ST_CHECK,
        ST_GOOD,
        ST_BAD
    } walk_state_e;
endpackage

// File: rtl/rxw_hdr_check.sv
module rxw_hdr_check
    import rxw_pkg::*;
#(
    parameter int unsigned CNT_W = 14
) (
    input  logic [WORD_W-1:0] evt_i,
    input  logic [WORD_W-1:0] sts_i,
    input  logic [WORD_W-1:0] cnt_i,
    output logic              present_o,
    output logic              good_o,
    output logic [CNT_W-1:0]  len_o
);
    // exact match on the readiness word
    assign present_o = (evt_i == EVT_FRAME);
    // masked status test
    assign good_o    = ((sts_i & STS_MASK) == STS_GOOD);
    // only the low bits of the count carry the length
    assign len_o     = cnt_i[CNT_W-1:0];
endmodule

// File: rtl/rxw_ptr_math.sv
module rxw_ptr_math
    import rxw_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 14
) (
    input  logic [ADDR_W-1:0]   start_i,
    input  logic [CNT_W-1:0]    len_i,
    input  logic [ADDR_W-9:0]   upper_page_i,
    output logic [ADDR_W-1:0]   pay_addr_o,
    output logic [CNT_W-1:0]    words_o,
    output logic [ADDR_W-1:0]   stop_o
);
    localparam int unsigned PAGE_W = ADDR_W - 8;

    logic [ADDR_W-1:0] end_sum;
    logic [ADDR_W-1:0] stop_base;
    logic [CNT_W:0]    len_round;

    assign pay_addr_o = start_i + ADDR_W'(HDR_BYTES);
    assign len_round  = {1'b0, len_i} + (CNT_W+1)'(3);
    assign words_o    = len_round[CNT_W:1];
    assign end_sum    = start_i + ADDR_W'(HDR_BYTES) + ADDR_W'(len_i);

    // an end that lands exactly on zero is replaced by the top of the region
    always_comb begin
        if (end_sum == '0)
            stop_base = {upper_page_i[PAGE_W-1:0], 8'hFF};
        else
            stop_base = end_sum;
    end

    assign stop_o = stop_base - ADDR_W'(1);
endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
    import rxw_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                poll_i,
    input  logic [ADDR_W-9:0]   lower_page_i,
    input  logic [ADDR_W-9:0]   upper_page_i,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic [ADDR_W-2:0]   mem_addr_o,
    output logic [WORD_W-1:0]   mem_wdata_o,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic                busy_o,
    output logic                frame_ready_o,
    output logic                rx_error_o,
    output logic [ADDR_W-1:0]   pay_addr_o,
    output logic [CNT_W-1:0]    pay_len_o,
    output logic [CNT_W-1:0]    pay_words_o,
    output logic [ADDR_W-1:0]   rd_ptr_o,
    output logic [ADDR_W-1:0]   stop_o,
    output logic                stop_wr_o
);
    localparam int unsigned WA_W = ADDR_W - 1;

    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] ptr_q, stop_q, pay_addr_q;
    logic [WORD_W-1:0] sts_q, lnk_q, cnt_q;
    logic [CNT_W-1:0]  len_q, words_q;

    logic              frm_present, frm_good;
    logic [CNT_W-1:0]  frm_len, calc_words;
    logic [ADDR_W-1:0] calc_pay_addr, calc_stop;
    logic [WA_W-1:0]   base_word;

    assign base_word = ptr_q[ADDR_W-1:1];

    rxw_hdr_check #(.CNT_W(CNT_W)) u_check (
        .evt_i     (mem_rdata_i),
        .sts_i     (sts_q),
        .cnt_i     (cnt_q),
        .present_o (frm_present),
        .good_o    (frm_good),
        .len_o     (frm_len)
    );

    rxw_ptr_math #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_math (
        .start_i      (ptr_q),
        .len_i        (frm_len),
        .upper_page_i (upper_page_i),
        .pay_addr_o   (calc_pay_addr),
        .words_o      (calc_words),
        .stop_o       (calc_stop)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (poll_i) state_d = ST_REQ_EVT;
            ST_CLEAR:   state_d = ST_IDLE;
            ST_REQ_EVT: state_d = ST_GET_EVT;
            ST_GET_EVT: state_d = frm_present ? ST_GET_STS : ST_IDLE;
            ST_GET_STS: state_d = ST_GET_LNK;
            ST_GET_LNK: state_d = ST_GET_CNT;
            ST_GET_CNT: state_d = ST_CHECK;
            ST_CHECK:   state_d = frm_good ? ST_GOOD : ST_BAD;
            ST_GOOD:    state_d = ST_IDLE;
            ST_BAD:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (init_i) state_d = ST_CLEAR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // header capture and pointer update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            stop_q     <= '0;
            sts_q      <= '0;
            lnk_q      <= '0;
            cnt_q      <= '0;
            pay_addr_q <= '0;
            len_q      <= '0;
            words_q    <= '0;
        end else if (init_i) begin
            ptr_q  <= {lower_page_i, 8'h00};
            stop_q <= {upper_page_i, 8'hFE};
        end else begin
            unique case (state_q)
                ST_GET_STS: sts_q <= mem_rdata_i;
                ST_GET_LNK: lnk_q <= mem_rdata_i;
                ST_GET_CNT: cnt_q <= mem_rdata_i;
                ST_CHECK: begin
                    if (frm_good) begin
                        ptr_q      <= lnk_q;
                        stop_q     <= calc_stop;
                        pay_addr_q <= calc_pay_addr;
                        len_q      <= frm_len;
                        words_q    <= calc_words;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_o      = 1'b0;
        mem_wr_o      = 1'b0;
        mem_addr_o    = base_word;
        mem_wdata_o   = '0;
        frame_ready_o = 1'b0;
        rx_error_o    = 1'b0;
        stop_wr_o     = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                mem_wr_o  = 1'b1;
                stop_wr_o = 1'b1;
            end
            ST_REQ_EVT: mem_rd_o = 1'b1;
            ST_GET_EVT: begin
                mem_rd_o   = frm_present;
                mem_addr_o = base_word + WA_W'(1);
            end
            ST_GET_STS: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = base_word + WA_W'(2);
            end
            ST_GET_LNK: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = base_word + WA_W'(3);
            end
            ST_GOOD: begin
                frame_ready_o = 1'b1;
                stop_wr_o     = 1'b1;
            end
            ST_BAD:  rx_error_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign rd_ptr_o    = ptr_q;
    assign stop_o      = stop_q;
    assign pay_addr_o  = pay_addr_q;
    assign pay_len_o   = len_q;
    assign pay_words_o = words_q;

    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ready_o && rx_error_o));
    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready_o |=> !frame_ready_o);
    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error_o |=> !rx_error_o);
    a_r5_err_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error_o |-> ($stable(ptr_q) && $stable(stop_q) && !stop_wr_o));
    a_r7_stop_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready_o |-> stop_wr_o);
    a_r3_no_frame_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GET_EVT && mem_rdata_i != EVT_FRAME && !init_i)
        |=> (state_q == ST_IDLE && $stable(ptr_q) && $stable(stop_q)));
    a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
endmodule

// File: tb/rx_ring_walker_tb_top.sv
module rx_ring_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0, poll_i = 1'b0;
    logic [7:0]  lower_page_i = 8'h00, upper_page_i = 8'h5F;
    logic        mem_rd_o, mem_wr_o;
    logic [14:0] mem_addr_o;
    logic [15:0] mem_wdata_o, mem_rdata_i;
    logic        busy_o, frame_ready_o, rx_error_o, stop_wr_o;
    logic [15:0] pay_addr_o, rd_ptr_o, stop_o;
    logic [13:0] pay_len_o, pay_words_o;

    logic [15:0] ram [0:32767];
    logic        tb_we = 1'b0;
    logic [14:0] tb_waddr = '0;
    logic [15:0] tb_wdata = '0;

    int checks = 0, errors = 0;
    int n_ready, n_err, n_stopwr, n_rd;
    logic [14:0] rd_log [0:7];

    always #2.5 clk = ~clk;

    rx_ring_walker dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .poll_i(poll_i),
        .lower_page_i(lower_page_i), .upper_page_i(upper_page_i),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .frame_ready_o(frame_ready_o), .rx_error_o(rx_error_o),
        .pay_addr_o(pay_addr_o), .pay_len_o(pay_len_o), .pay_words_o(pay_words_o),
        .rd_ptr_o(rd_ptr_o), .stop_o(stop_o), .stop_wr_o(stop_wr_o)
    );

    // RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (tb_we)    ram[tb_waddr] <= tb_wdata;
        if (mem_wr_o) ram[mem_addr_o] <= mem_wdata_o;
        if (mem_rd_o) mem_rdata_i <= ram[mem_addr_o];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put_word(input logic [15:0] byte_addr, input logic [15:0] val);
        @(negedge clk);
        tb_we = 1'b1; tb_waddr = byte_addr[15:1]; tb_wdata = val;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_frame(input logic [15:0] at, input logic [15:0] evt,
                             input logic [15:0] sts, input logic [15:0] lnk,
                             input logic [15:0] cnt);
        put_word(at,          evt);
        put_word(at + 16'd2,  sts);
        put_word(at + 16'd4,  lnk);
        put_word(at + 16'd6,  cnt);
    endtask

    // one poll; extra_at>0 raises poll again during the walk
    task automatic run_poll(input int extra_at);
        n_ready = 0; n_err = 0; n_stopwr = 0; n_rd = 0;
        @(negedge clk); poll_i = 1'b1;
        @(negedge clk); poll_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            poll_i = (extra_at > 0 && i == extra_at);
            if (frame_ready_o) n_ready++;
            if (rx_error_o)    n_err++;
            if (stop_wr_o)     n_stopwr++;
            if (mem_rd_o && n_rd < 8) begin rd_log[n_rd] = mem_addr_o; n_rd++; end
            if (!busy_o && !poll_i) break;
            @(negedge clk);
        end
        poll_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (frame_ready_o) n_ready++;
            if (rx_error_o)    n_err++;
        end
    endtask

    task automatic do_init(input logic [7:0] lo, input logic [7:0] hi);
        int sw = 0;
        lower_page_i = lo; upper_page_i = hi;
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
        if (stop_wr_o) sw++;
        @(negedge clk);
        check(rd_ptr_o == {lo, 8'h00}, "R2 ptr", rd_ptr_o, {lo, 8'h00});
        check(stop_o == {hi, 8'hFE}, "R2 stop", stop_o, {hi, 8'hFE});
        check(sw == 1, "R2 stop_wr", sw, 1);
        check(ram[{lo, 7'h00}] == 16'h0, "R2 clear", ram[{lo, 7'h00}], 0);
    endtask

    task automatic t_reset();
        check(!busy_o && !frame_ready_o && !rx_error_o && !stop_wr_o, "R1 outputs",
              {busy_o, frame_ready_o, rx_error_o, stop_wr_o}, 0);
        check(rd_ptr_o == 16'h0, "R1 ptr", rd_ptr_o, 0);
    endtask

    task automatic t_no_frame(input logic [15:0] evt);
        logic [15:0] p0, s0;
        p0 = rd_ptr_o; s0 = stop_o;
        if (evt != 16'hFFFF) put_word(p0, evt);
        run_poll(0);
        check(n_ready == 0 && n_err == 0 && n_stopwr == 0, "R3 no pulse",
              n_ready + n_err + n_stopwr, 0);
        check(rd_ptr_o == p0 && stop_o == s0, "R3 unchanged", rd_ptr_o, p0);
    endtask

    task automatic t_good(input logic [15:0] sts, input logic [15:0] lnk,
                          input logic [15:0] cnt, input logic [15:0] exp_stop,
                          input logic [7:0] tag_n);
        logic [15:0] p0; logic [13:0] len;
        p0 = rd_ptr_o; len = cnt[13:0];
        put_frame(p0, 16'h0008, sts, lnk, cnt);
        run_poll(0);
        check(n_ready == 1 && n_err == 0, "R5 good", n_ready, 1);
        check(n_stopwr == 1, "R7 stop_wr", n_stopwr, 1);
        check(rd_ptr_o == lnk, "R7 ptr", rd_ptr_o, lnk);
        check(stop_o == exp_stop, (tag_n == 8) ? "R8 wrap stop" : "R7 stop", stop_o, exp_stop);
        check(pay_len_o == len, "R6 len", pay_len_o, len);
        check(pay_addr_o == p0 + 16'd8, "R6 addr", pay_addr_o, p0 + 16'd8);
        check(pay_words_o == 14'((15'(len) + 15'd3) >> 1), "R6 words", pay_words_o,
              (int'(len) + 3) >> 1);
        for (int k = 0; k < 4; k++)
            check(n_rd == 4 && rd_log[k] == p0[15:1] + 15'(k), "R4 read order",
                  rd_log[k], p0[15:1] + 15'(k));
    endtask

    task automatic t_bad(input logic [15:0] sts);
        logic [15:0] p0, s0;
        p0 = rd_ptr_o; s0 = stop_o;
        put_frame(p0, 16'h0008, sts, 16'h1234, 16'h0010);
        run_poll(0);
        check(n_err == 1 && n_ready == 0 && n_stopwr == 0, "R5 error", n_err, 1);
        check(rd_ptr_o == p0 && stop_o == s0, "R5 unchanged", rd_ptr_o, p0);
    endtask

    task automatic t_busy_poll();
        logic [15:0] p0;
        p0 = rd_ptr_o;
        put_frame(p0, 16'h0008, 16'h2000, p0, 16'h0002);
        run_poll(2);
        check(n_ready == 1, "R9 poll ignored while busy", n_ready, 1);
        check(stop_o == p0 + 16'd9, "R9 stop", stop_o, p0 + 16'd9);
    endtask

    initial begin
        #(5 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        put_word(16'h0000, 16'h0008);
        do_init(8'h00, 8'h5F);
        t_no_frame(16'hFFFF);       // cleared header word
        t_no_frame(16'h0009);
        t_no_frame(16'h0108);
        t_good(16'h2040, 16'h0050, 16'hC040, 16'h0047, 8'd7);
        t_bad(16'h2001);
        t_bad(16'h0000);
        t_bad(16'h2C00);
        t_good(16'hF27E, 16'hFFF0, 16'h0005, 16'h005C, 8'd7);
        t_good(16'h2000, 16'h0100, 16'h0008, 16'h5FFE, 8'd8);   // end wraps to zero
        t_good(16'h2000, 16'h0200, 16'hFFFF, 16'h4106, 8'd6);
        t_busy_poll();
        put_word(16'h2000, 16'h0008);
        do_init(8'h20, 8'h7F);
        t_no_frame(16'hFFFF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule